// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master. It runs from a functional clock. A programmable prescaler turns that clock into an internal tick. Two counters, one for the low half and one for the high half of each SCL period, count those ticks. The low half lasts seven ticks more than its programmed count, and the high half lasts five ticks more than its programmed count. The block drives the line only through an open-drain pull-down request. The released level is read back on `scl_in`, so a slave that holds the line low delays the high half.

Each configuration word carries two timing counts:
- The lower byte holds the count for standard/fast operation. This count is also used for the first (arbitration) phase of a high-speed transfer.
- The upper byte holds the count for the high-speed data phase.

A phase input picks between the two counts. The prescaler value and the picked counts are captured at the start of every low half. A change made mid-period therefore takes effect only with the next period.

The block sends two one-cycle strobes to the bit engine:
- A falling-edge strobe, marking when data may change.
- A rising-edge strobe, marking when the line has been seen high and data may be sampled.

Top module: `i2c_scl_gen`

## Requirements
- R1: While enabled, each pull-down interval lasts exactly (P+1)×(L+7) functional-clock cycles. P is the prescaler value and L is the selected low-count byte.
- R2: When the line rises as soon as it is released, each released interval lasts exactly (P+1)×(H+5) functional-clock cycles. H is the selected high-count byte.
- R3: With `hs_phase` = 0, bits [7:0] of each configuration word set the timing and bits [15:8] have no effect. With `hs_phase` = 1, bits [15:8] set the timing and bits [7:0] have no effect.
- R4: The high count advances only after `scl_in` has been sampled high. If the line is held low for S cycles after release, the released interval lasts S+(P+1)×(H+5) cycles, and the block does not pull the line low during the stretch.
- R5: When `enable` is sampled low, `scl_drive_low`, `fall_stb` and `rise_stb` are all 0 from the next cycle on. A later enable starts a fresh, full-length low interval.
- R6: The prescaler value, both timing counts and the phase selection are captured at the first cycle of each low interval. Changes made afterwards affect neither that low interval nor the high interval that follows it.
- R7: `fall_stb` is 1 for exactly the first cycle of each pull-down interval and is 0 at all other times.
- R8: `rise_stb` is 1 for exactly one cycle: the cycle after the first clock edge at which `scl_in` is sampled high following a release. It is 0 at all other times.
- R9: During and after reset, with `enable` low, `scl_drive_low`, `fall_stb` and `rise_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases the line and clears the counters |
| psc_div | input | 8 | Prescaler value P; one tick every P+1 clocks |
| low_cfg | input | 16 | Low-time counts: [7:0] standard/fast, [15:8] high-speed |
| high_cfg | input | 16 | High-time counts: [7:0] standard/fast, [15:8] high-speed |
| hs_phase | input | 1 | 1 selects the high-speed counts |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_drive_low | output | 1 | 1 requests the open-drain pull-down |
| fall_stb | output | 1 | One-cycle strobe at the start of each low interval |
| rise_stb | output | 1 | One-cycle strobe once the released line is seen high |

## Verification
The hardest situation to reach from the ports is a configuration change that lands after the capture point but inside a running period. The change must then leave the current low interval and the following high interval untouched, and only the next period may pick it up.

The stimulus waits on the second falling-edge strobe and then, one cycle later, changes the prescaler, the counts or the phase select. The scoreboard already holds expectations for two old-timing periods followed by new-timing periods.

Clock stretching is reached the same way. The bench's line model holds `scl_in` low for a set number of cycles after a chosen release, and the expected high width and strobe position are shifted by that amount.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int PSC_W    = 8,
  parameter int CNT_W    = 8,
  parameter int LOW_ADD  = 7,
  parameter int HIGH_ADD = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [PSC_W-1:0]     psc_div,
  input  logic [2*CNT_W-1:0]   low_cfg,
  input  logic [2*CNT_W-1:0]   high_cfg,
  input  logic                 hs_phase,
  input  logic                 scl_in,
  output logic                 scl_drive_low,
  output logic                 fall_stb,
  output logic                 rise_stb
);

  localparam int TW    = CNT_W + 1;
  localparam int CFG_W = 2 * CNT_W;

  typedef enum logic [1:0] {ST_OFF, ST_LOW, ST_HIGH} state_t;

  state_t           state;
  logic [PSC_W-1:0] pre_cnt, psc_q;
  logic [TW-1:0]    ph_cnt, low_q, high_q;
  logic             hi_seen;

  logic [CNT_W-1:0] low_sel, high_sel;
  logic [TW-1:0]    low_len, high_len;
  logic             tick, counting, low_done, high_done, start_low;

  assign low_sel  = hs_phase ? low_cfg[CFG_W-1:CNT_W]  : low_cfg[CNT_W-1:0];
  assign high_sel = hs_phase ? high_cfg[CFG_W-1:CNT_W] : high_cfg[CNT_W-1:0];
  assign low_len  = TW'(low_sel)  + TW'(LOW_ADD);
  assign high_len = TW'(high_sel) + TW'(HIGH_ADD);

  assign tick      = (pre_cnt == psc_q);
  assign counting  = (state == ST_LOW) || (state == ST_HIGH && (hi_seen || scl_in));
  assign low_done  = (state == ST_LOW) && tick && (ph_cnt == low_q - TW'(1));
  assign high_done = (state == ST_HIGH) && counting && tick && (ph_cnt == high_q - TW'(1));
  assign start_low = (state == ST_OFF && enable) || high_done;

  assign scl_drive_low = (state == ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      psc_q    <= '0;
      low_q    <= '0;
      high_q   <= '0;
      hi_seen  <= 1'b0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else if (!enable) begin
      state    <= ST_OFF;
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      hi_seen  <= 1'b0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      fall_stb <= start_low;
      rise_stb <= 1'b0;
      if (start_low) begin
        state   <= ST_LOW;
        psc_q   <= psc_div;
        low_q   <= low_len;
        high_q  <= high_len;
        pre_cnt <= '0;
        ph_cnt  <= '0;
        hi_seen <= 1'b0;
      end else if (low_done) begin
        state   <= ST_HIGH;
        pre_cnt <= '0;
        ph_cnt  <= '0;
        hi_seen <= 1'b0;
      end else begin
        if (counting) begin
          if (tick) begin
            pre_cnt <= '0;
            ph_cnt  <= ph_cnt + TW'(1);
          end else begin
            pre_cnt <= pre_cnt + PSC_W'(1);
          end
        end
        if (state == ST_HIGH && !hi_seen && scl_in) begin
          hi_seen  <= 1'b1;
          rise_stb <= 1'b1;
        end
      end
    end
  end

  AST_LOW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LOW |-> ph_cnt < low_q); // R1
  AST_HIGH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HIGH |-> ph_cnt < high_q); // R2
  AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && !hi_seen && !scl_in) |=> (ph_cnt == '0 && !scl_drive_low)); // R4
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !fall_stb && !rise_stb)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !start_low) |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q))); // R6
  AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_drive_low); // R7
  AST_FALL_ON_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_stb); // R7
  AST_RISE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (!scl_drive_low && $past(scl_in))); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb)); // R8

endmodule

// File: tb/i2c_scl_gen_test.sv
module i2c_scl_gen_test;

  typedef struct {
    bit    is_low;
    int    width;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        hs_phase = 1'b0;
  logic [7:0]  psc_div = '0;
  logic [15:0] low_cfg = '0;
  logic [15:0] high_cfg = '0;
  logic        scl_in;
  logic        drive_low, fall_stb, rise_stb;

  int   checks = 0;
  int   fails = 0;
  bit   finished = 0;
  int   hold_cnt = 0;
  int   stretch_next = 0;
  int   cur_stretch = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  assign scl_in = !drive_low && (hold_cnt == 0);

  i2c_scl_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .psc_div(psc_div),
    .low_cfg(low_cfg), .high_cfg(high_cfg), .hs_phase(hs_phase),
    .scl_in(scl_in), .scl_drive_low(drive_low), .fall_stb(fall_stb),
    .rise_stb(rise_stb)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(bit is_low, int w, string tag);
    exp_t e;
    e.is_low = is_low;
    e.width  = w;
    e.tag    = tag;
    q.push_back(e);
  endtask

  task automatic push_pair(int p, int l, int h, string tl, string th);
    push(1'b1, (p + 1) * (l + 7), tl);
    push(1'b0, (p + 1) * (h + 5), th);
  endtask

  task automatic setup(int p, logic [15:0] lc, logic [15:0] hc, logic hs);
    @(posedge clk); #1;
    psc_div = 8'(p); low_cfg = lc; high_cfg = hc; hs_phase = hs;
  endtask

  task automatic go();
    @(posedge clk); #1;
    enable = 1'b1;
  endtask

  task automatic drain_and_stop();
    while (q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
    enable = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor / scoreboard
  bit armed = 0;
  bit prev = 0;
  int run = 0;
  int rel = 0;
  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      armed = 0; run = 0; rel = 0; hold_cnt = 0; cur_stretch = 0;
    end else if (!armed) begin
      if (drive_low) begin
        armed = 1; run = 1; prev = 1;
        check(fall_stb == 1'b1, "R7", "fall strobe on first low cycle", int'(fall_stb), 1);
        if (rise_stb) check(0, "R8", "rise strobe during low", 1, 0);
      end
    end else begin
      if (drive_low == prev) begin
        run++;
        if (!drive_low && hold_cnt > 0) hold_cnt--;
      end else begin
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(e.is_low == prev && run == e.width, e.tag,
                prev ? "low width" : "high width", run, e.width);
        end
        run = 1;
        prev = drive_low;
        if (drive_low) begin
          check(fall_stb == 1'b1, "R7", "fall strobe on first low cycle", int'(fall_stb), 1);
        end else begin
          rel = 0;
          cur_stretch = stretch_next;
          stretch_next = 0;
          hold_cnt = cur_stretch;
        end
      end
      if (fall_stb && !(drive_low && run == 1)) check(0, "R7", "stray fall strobe", 1, 0);
      if (!drive_low) begin
        rel++;
        if (rel == cur_stretch + 2)
          check(rise_stb == 1'b1, "R8", "rise strobe after line seen high", int'(rise_stb), 1);
        else if (rise_stb)
          check(0, "R8", "stray rise strobe", 1, 0);
      end else if (rise_stb) begin
        check(0, "R8", "rise strobe during low", 1, 0);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      check(0, "watchdog", "run did not finish", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    check(drive_low == 1'b0, "R9", "drive in reset", int'(drive_low), 0);
    check(fall_stb == 1'b0 && rise_stb == 1'b0, "R9", "strobes in reset",
          int'(fall_stb) + int'(rise_stb), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(drive_low == 1'b0, "R9", "drive idle after reset", int'(drive_low), 0);
    check(fall_stb == 1'b0 && rise_stb == 1'b0, "R9", "strobes idle after reset",
          int'(fall_stb) + int'(rise_stb), 0);

    // R1 R2: basic widths, no prescale
    setup(0, 16'h0003, 16'h0002, 1'b0);
    repeat (3) push_pair(0, 3, 2, "R1", "R2");
    go();
    drain_and_stop();

    // R1 R2: prescaled
    setup(2, 16'h0005, 16'h0001, 1'b0);
    repeat (2) push_pair(2, 5, 1, "R1", "R2");
    go();
    drain_and_stop();

    // R3 R6: upper bytes ignored while hs_phase=0, then phase switch mid-period
    setup(1, {8'd4, 8'd20}, {8'd0, 8'd10}, 1'b0);
    push_pair(1, 20, 10, "R3", "R3");
    push_pair(1, 20, 10, "R6", "R6");
    push_pair(1, 4, 0, "R3", "R3");
    push_pair(1, 4, 0, "R3", "R3");
    go();
    repeat (2) @(posedge fall_stb);
    @(posedge clk); #1;
    hs_phase = 1'b1;
    drain_and_stop();

    // R3: lower bytes ignored while hs_phase=1
    setup(0, {8'd2, 8'd30}, {8'd1, 8'd25}, 1'b1);
    repeat (2) push_pair(0, 2, 1, "R3", "R3");
    go();
    drain_and_stop();

    // R6: prescaler and counts changed inside a running period
    setup(0, 16'h0001, 16'h0001, 1'b0);
    push_pair(0, 1, 1, "R6", "R6");
    push_pair(0, 1, 1, "R6", "R6");
    push_pair(1, 2, 3, "R6", "R6");
    go();
    repeat (2) @(posedge fall_stb);
    @(posedge clk); #1;
    psc_div = 8'd1; low_cfg = 16'h0002; high_cfg = 16'h0003;
    drain_and_stop();

    // R4: slave stretches the first high half by 5 cycles
    setup(0, 16'h0002, 16'h0003, 1'b0);
    stretch_next = 5;
    push(1'b1, 9, "R4");
    push(1'b0, 5 + 8, "R4");
    push_pair(0, 2, 3, "R4", "R4");
    go();
    drain_and_stop();

    // R5: disable mid-low, then fresh full period
    setup(1, 16'h000A, 16'h0002, 1'b0);
    go();
    @(posedge fall_stb);
    repeat (5) @(posedge clk);
    #1 enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(drive_low == 1'b0, "R5", "release after disable", int'(drive_low), 0);
    check(fall_stb == 1'b0 && rise_stb == 1'b0, "R5", "strobes after disable",
          int'(fall_stb) + int'(rise_stb), 0);
    repeat (4) @(negedge clk);
    check(drive_low == 1'b0, "R5", "held released while disabled", int'(drive_low), 0);
    push_pair(1, 10, 2, "R5", "R5");
    go();
    drain_and_stop();

    finished = 1;
    summary();
    $finish;
  end

endmodule